// File: doc/BRIEF.md
# Oversampled Serial Receiver with Flag-Tagged Character Queue

This block is the receive half of a fixed-format asynchronous serial port. Frames are always 8 data bits, no parity and one stop bit. An oversampling strobe `os_tick` arrives at 14 times the bit rate and paces the receiver. The receiver confirms a start bit at its midpoint, samples each data bit once per bit period (least significant bit first) and checks the stop bit. Each completed frame is written into a 64-entry queue together with a framing-error flag and a break flag.

The consumer sees the head of the queue as one 11-bit word. That word holds the character, an empty marker and the two flags that belong to that character. The block also gives the number of characters held and raises two requests. The trigger request is set while the fill reaches a selectable threshold. The timeout request is set when unread data has sat untouched for a selectable number of character times. A character that finds the queue full is dropped and reported with a one-cycle overrun pulse. The baud strobe, the bus interface and interrupt latching belong to the surrounding logic.

Top module: `serial_rx_queue`

## Requirements
- R1: After synchronous reset, `rd_word` is 0x100, `rx_level` is 0, and `trig_req`, `tmo_req` and `overrun` are low.
- R2: Frames are 8N1, LSB first, with 14 ticks per bit. With `os_tick` held high, take E0 as the first rising edge at which `rx_line` is low. The character is visible at the outputs after edge E136.
- R3: A low pulse on `rx_line` that ends before the start-bit midpoint (7 ticks) is discarded and writes nothing.
- R4: `rd_word` shows the head entry with no added latency. Bits [7:0] hold the character, bit 8 is set only when the queue is empty, bit 9 holds the framing flag and bit 10 holds the break flag. `rd_en` high at a rising edge removes the head entry.
- R5: A frame whose stop bit samples low is stored with bit 9 set. The receiver then waits for the line to return high before it looks for another start bit.
- R6: A frame whose data bits and stop bit all sample low is stored as 0x600 (bits 9 and 10 set, character 0). Only one such entry is written, however long the line then stays low.
- R7: The queue holds up to 64 entries. `rx_level` always equals the number of entries held.
- R8: A character that arrives while 64 entries are held, with no read at the same edge, is dropped. `overrun` pulses for one cycle and the stored entries are unchanged.
- R9: `trig_sel` codes 0,1,2,3,4,5 select thresholds of 1,4,8,16,32,48 characters, and codes 6 and 7 select 48. `trig_req` is high while `rx_level` is at or above the threshold.
- R10: `tmo_sel` code 0 disables the timeout, and codes 1,2,3 select 4, 8 or 16 character times (one character time is 140 ticks). An idle counter clears at every edge with an arriving character, a read, or an empty queue, and otherwise counts ticks. `tmo_req` is high while the queue is non-empty and the counter has reached the selected limit.
- R11: `rd_en` on an empty queue leaves the queue unchanged: `rd_word` stays 0x100, and the next character written is the next one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling strobe, 14 per bit period |
| rx_line | input | 1 | Serial receive line, idle high |
| rd_en | input | 1 | Remove head entry at this edge |
| trig_sel | input | 3 | Trigger threshold code |
| tmo_sel | input | 2 | Inactivity timeout code |
| rd_word | output | 11 | {break, framing, empty, character[7:0]} |
| rx_level | output | 8 | Number of entries held |
| trig_req | output | 1 | Fill at or above threshold |
| tmo_req | output | 1 | Unread data left idle too long |
| overrun | output | 1 | One-cycle pulse for a dropped character |

## Verification
The bench builds the block with its defaults: 14 samples per bit and 64 entries. It holds `os_tick` high, so a frame takes 140 cycles. With that, filling the queue to its limit and forcing a dropped character fits in about nine thousand cycles, and the 4-character timeout expires after 560 idle cycles. The reference model tracks queue contents, the idle counter and the expected overrun pulse edge by edge. It compares every output on every clock. It also covers glitch rejection, framing, break, reads from an empty queue, and changes of the threshold code while the queue is full.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned FRAME_BITS = 10;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic [7:0] data;
    } rxq_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP,
        S_WAITHI
    } rxq_state_t;

    function automatic int unsigned trig_threshold(input logic [2:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 4;
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 32;
            default: return 48;
        endcase
    endfunction

    function automatic int unsigned tmo_chars(input logic [1:0] code);
        case (code)
            2'd1:    return 4;
            2'd2:    return 8;
            2'd3:    return 16;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
    import rxq_pkg::*;
#(
    parameter int OSR = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx_line,
    output logic       out_valid,
    output rxq_entry_t out_entry
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] HALF_M1 = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST    = CW'(OSR - 1);

    logic [1:0]    sync_q;
    logic          rx_s;
    rxq_state_t    state;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    shreg;

    assign rx_s = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 2'b11;
            state     <= S_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            shreg     <= '0;
            out_valid <= 1'b0;
            out_entry <= '0;
        end else begin
            sync_q    <= {sync_q[0], rx_line};
            out_valid <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (!rx_s) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == HALF_M1) begin
                            cnt   <= '0;
                            bitn  <= '0;
                            state <= rx_s ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {rx_s, shreg[7:1]};
                            bitn  <= bitn + 1'b1;
                            if (bitn == 3'd7) state <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == LAST) begin
                            cnt            <= '0;
                            out_valid      <= 1'b1;
                            out_entry.data <= shreg;
                            out_entry.fe   <= !rx_s;
                            out_entry.brk  <= !rx_s && (shreg == 8'h00);
                            state          <= rx_s ? S_IDLE : S_WAITHI;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (rx_s) state <= S_IDLE;
                    end
                endcase
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R2
    AST_BRK_TAGGED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_entry.brk) |-> (out_entry.fe && out_entry.data == 8'h00)); // R6

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_valid,
    input  rxq_entry_t                   wr_entry,
    input  logic                         rd_en,
    output rxq_entry_t                   head,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         pop,
    output logic                         overrun
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    rxq_entry_t  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, wr_ok;

    assign empty = (count == '0);
    assign full  = (count == CNTW'(DEPTH));
    assign pop   = rd_en && !empty;
    assign wr_ok = wr_valid && (!full || pop);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= wr_valid && !wr_ok;
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop)   rd_ptr <= rd_ptr + 1'b1;
            case ({wr_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNTW'(DEPTH)); // R7
    AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (count == CNTW'(DEPTH) && $past(count) == CNTW'(DEPTH))); // R8
    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && !wr_valid) |=> (count == '0 && $stable(rd_ptr))); // R11

endmodule

// File: rtl/rxq_requests.sv
module rxq_requests
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int OSR   = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic                       wr_seen,
    input  logic                       pop,
    input  logic [2:0]                 trig_sel,
    input  logic [1:0]                 tmo_sel,
    output logic                       trig_req,
    output logic                       tmo_req
);
    localparam int CNTW       = $clog2(DEPTH + 1);
    localparam int CHAR_TICKS = FRAME_BITS * OSR;
    localparam int TMO_MAX    = 16 * CHAR_TICKS;
    localparam int TW         = $clog2(TMO_MAX + 1);

    logic [CNTW-1:0] thr;
    logic [TW-1:0]   limit;
    logic [TW-1:0]   idle;

    assign thr      = CNTW'(trig_threshold(trig_sel));
    assign limit    = TW'(tmo_chars(tmo_sel) * CHAR_TICKS);
    assign trig_req = (count >= thr);
    assign tmo_req  = (tmo_sel != 2'd0) && (count != '0) && (idle >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle <= '0;
        end else if (wr_seen || pop || count == '0) begin
            idle <= '0;
        end else if (tick && idle != TW'(TMO_MAX)) begin
            idle <= idle + 1'b1;
        end
    end

    AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        trig_req |-> count != '0); // R9
    AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        tmo_req |-> count != '0); // R10
    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (wr_seen || pop) |=> !tmo_req); // R10

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import rxq_pkg::*;
#(
    parameter int OSR   = 14,
    parameter int DEPTH = 64,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             os_tick,
    input  logic             rx_line,
    input  logic             rd_en,
    input  logic [2:0]       trig_sel,
    input  logic [1:0]       tmo_sel,
    output logic [10:0]      rd_word,
    output logic [LVL_W-1:0] rx_level,
    output logic             trig_req,
    output logic             tmo_req,
    output logic             overrun
);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic            rx_valid;
    rxq_entry_t      rx_entry;
    rxq_entry_t      head;
    logic            empty;
    logic            pop;
    logic [CNTW-1:0] count;

    rxq_sampler #(.OSR(OSR)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .tick      (os_tick),
        .rx_line   (rx_line),
        .out_valid (rx_valid),
        .out_entry (rx_entry)
    );

    rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (rx_valid),
        .wr_entry (rx_entry),
        .rd_en    (rd_en),
        .head     (head),
        .empty    (empty),
        .count    (count),
        .pop      (pop),
        .overrun  (overrun)
    );

    rxq_requests #(.DEPTH(DEPTH), .OSR(OSR)) u_req (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .count    (count),
        .wr_seen  (rx_valid),
        .pop      (pop),
        .trig_sel (trig_sel),
        .tmo_sel  (tmo_sel),
        .trig_req (trig_req),
        .tmo_req  (tmo_req)
    );

    assign rd_word  = empty ? 11'h100 : {head.brk, head.fe, 1'b0, head.data};
    assign rx_level = LVL_W'(count);

    AST_EMPTY_FLAG_LEVEL: assert property (@(posedge clk) disable iff (rst)
        rd_word[8] |-> (rx_level == '0 && rd_word[10:9] == 2'b00)); // R4

endmodule

// File: tb/serial_rx_queue_test.sv
module serial_rx_queue_test;
    localparam int OSR   = 14;
    localparam int DEPTH = 64;
    localparam int CHAR  = 10 * OSR;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        os_tick = 1'b1;
    logic        rx_line = 1'b1;
    logic        rd_en = 1'b0;
    logic [2:0]  trig_sel = 3'd0;
    logic [1:0]  tmo_sel = 2'd0;
    logic [10:0] rd_word;
    logic [7:0]  rx_level;
    logic        trig_req, tmo_req, overrun;

    serial_rx_queue #(.OSR(OSR), .DEPTH(DEPTH), .LVL_W(8)) uut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
        .rd_en(rd_en), .trig_sel(trig_sel), .tmo_sel(tmo_sel),
        .rd_word(rd_word), .rx_level(rx_level), .trig_req(trig_req),
        .tmo_req(tmo_req), .overrun(overrun)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ovr_count = 0;

    // reference model state
    logic [9:0] q[$];
    int         cyc = 0;
    bit         sched_valid = 1'b0;
    int         sched_at = 0;
    logic [9:0] sched_val = '0;
    int         idle = 0;
    bit         exp_ovr = 1'b0;

    function automatic int thr_of(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 16;
            3'd4: return 32;
            default: return 48;
        endcase
    endfunction

    function automatic int tmo_lim(input logic [1:0] c);
        return (c == 2'd1) ? 4 * CHAR : (c == 2'd2) ? 8 * CHAR : 16 * CHAR;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        int pre;
        bit push, pop;
        cyc++;
        if (rst) begin
            q.delete();
            idle = 0;
            exp_ovr = 1'b0;
        end else begin
            pre = q.size();
            push = sched_valid && (cyc == sched_at);
            pop = rd_en && (pre > 0);
            exp_ovr = 1'b0;
            if (pop) void'(q.pop_front());
            if (push) begin
                sched_valid = 1'b0;
                if (pre < DEPTH || pop) q.push_back(sched_val);
                else exp_ovr = 1'b1;
            end
            if (push || pop || pre == 0) idle = 0;
            else if (os_tick && idle < 16 * CHAR) idle++;
        end
    end

    always @(negedge clk) begin
        logic [10:0] ew;
        bit et, eo;
        if (!rst && !done) begin
            ew = (q.size() == 0) ? 11'h100 : {q[0][9:8], 1'b0, q[0][7:0]};
            et = (q.size() >= thr_of(trig_sel));
            eo = (tmo_sel != 2'd0) && (q.size() != 0) && (idle >= tmo_lim(tmo_sel));
            if (overrun) ovr_count++;
            chk(rd_word == ew, "R4 read word", int'(rd_word), int'(ew));
            chk(int'(rx_level) == q.size(), "R7 level", int'(rx_level), q.size());
            chk(trig_req == et, "R9 trigger", int'(trig_req), int'(et));
            chk(tmo_req == eo, "R10 timeout", int'(tmo_req), int'(eo));
            chk(overrun == exp_ovr, "R8 overrun pulse", int'(overrun), int'(exp_ovr));
        end
    end

    task automatic send(input logic [7:0] d, input logic stopb);
        @(negedge clk);
        sched_val   = {(!stopb && d == 8'h00), !stopb, d};
        sched_at    = cyc + 1 + 136;
        sched_valid = 1'b1;
        rx_line = 1'b0;
        repeat (OSR) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            repeat (OSR) @(negedge clk);
        end
        rx_line = stopb;
        repeat (OSR) @(negedge clk);
        rx_line = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic read_expect(input logic [10:0] exp, input string tag);
        @(negedge clk);
        chk(rd_word == exp, tag, int'(rd_word), int'(exp));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 1) & 255);
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rd_word == 11'h100, "R1 word", int'(rd_word), 'h100);
        chk(rx_level == 8'd0, "R1 level", int'(rx_level), 0);
        chk({trig_req, tmo_req, overrun} == 3'b000, "R1 requests", int'({trig_req, tmo_req, overrun}), 0);

        // R2 normal character
        send(8'hA5, 1'b1);
        chk(rx_level == 8'd1, "R2 level", int'(rx_level), 1);
        read_expect(11'h0A5, "R2 char");

        // R3 short glitch ignored
        @(negedge clk);
        rx_line = 1'b0;
        repeat (3) @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk(rx_level == 8'd0, "R3 glitch", int'(rx_level), 0);

        // R5 framing error
        send(8'h3C, 1'b0);
        read_expect(11'h23C, "R5 framing flag");

        // R6 break: line low for a long time, one entry
        @(negedge clk);
        sched_val   = 10'h300;
        sched_at    = cyc + 1 + 136;
        sched_valid = 1'b1;
        rx_line = 1'b0;
        repeat (400) @(negedge clk);
        rx_line = 1'b1;
        repeat (6) @(negedge clk);
        chk(rx_level == 8'd1, "R6 single break entry", int'(rx_level), 1);
        read_expect(11'h600, "R6 break word");

        // R11 read on empty
        @(negedge clk);
        rd_en = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b0;
        chk(rd_word == 11'h100, "R11 empty word", int'(rd_word), 'h100);
        send(8'h11, 1'b1);
        read_expect(11'h011, "R11 order kept");

        // R10 timeout
        tmo_sel = 2'd1;
        send(8'h22, 1'b1);
        repeat (500) @(negedge clk);
        chk(tmo_req == 1'b0, "R10 before limit", int'(tmo_req), 0);
        repeat (100) @(negedge clk);
        chk(tmo_req == 1'b1, "R10 after limit", int'(tmo_req), 1);
        read_expect(11'h022, "R10 char");
        chk(tmo_req == 1'b0, "R10 cleared", int'(tmo_req), 0);
        tmo_sel = 2'd3;

        // R7 / R9 / R8 fill and overflow
        trig_sel = 3'd4;
        for (int i = 0; i < DEPTH; i++) send(pat(i), 1'b1);
        chk(rx_level == 8'd64, "R7 full level", int'(rx_level), 64);
        chk(trig_req == 1'b1, "R9 threshold 32", int'(trig_req), 1);
        send(8'hEE, 1'b1);
        chk(ovr_count == 1, "R8 one overrun pulse", ovr_count, 1);
        chk(rx_level == 8'd64, "R8 level kept", int'(rx_level), 64);
        trig_sel = 3'd5;
        @(negedge clk);
        chk(trig_req == 1'b1, "R9 threshold 48 at 64", int'(trig_req), 1);
        for (int i = 0; i < 20; i++) read_expect({3'b000, pat(i)}, "R8 contents");
        chk(trig_req == 1'b0, "R9 threshold 48 at 44", int'(trig_req), 0);
        trig_sel = 3'd7;
        @(negedge clk);
        chk(trig_req == 1'b0, "R9 code 7 as 48", int'(trig_req), 0);
        trig_sel = 3'd3;
        @(negedge clk);
        chk(trig_req == 1'b1, "R9 threshold 16", int'(trig_req), 1);
        for (int i = 20; i < DEPTH; i++) read_expect({3'b000, pat(i)}, "R7 drain order");
        @(negedge clk);
        chk(rd_word == 11'h100, "R4 empty after drain", int'(rd_word), 'h100);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule